// File: doc/BRIEF.md
# SD/MMC Command Response Receiver

This block takes in the response a memory card returns on the serial command line after a command has gone out. It arms itself when the command transmitter reports that its command is done, but only if a response was asked for. It then samples the line once per bit-clock strobe and waits for the first low bit, which is the start bit. From there it shifts in either a 48-bit short response or a 136-bit long response, as the format input selects. Each group of eight bits is written, most significant bit first, into a 17-entry byte store.

Software reads the store one byte at a time through a read port. The port has its own pointer, which software can send back to entry zero. When the last bit arrives, the block checks the frame. A CRC status bit reports whether the received CRC7 matches the one it computed, and a format status bit reports whether the transmission bit and the end bit are correct. An end-of-response flag is then set. This flag stays set until it is cleared and, when enabled, drives an interrupt output. If the line stays high for too long while the block is waiting for a start bit, the block gives up and raises the same flag.

Top module: `sd_resp_rx`

## Requirements
- R1: The block arms (`busy` goes high on the next cycle) only when `cmd_done` is pulsed while `rx_en` is 1. With `rx_en` at 0, a complete frame on the line leaves `busy` and `resp_done` low.
- R2: While armed, every sampled bit that is 1 is ignored. The first sampled 0 is the start bit and becomes the most significant bit of stored byte 0.
- R3: With `long_fmt` = 0 when the block arms, 48 bits are received and stored as 6 bytes in entries 0 to 5, in arrival order, with the earliest bit in bit 7 of each byte.
- R4: With `long_fmt` = 1 when the block arms, 136 bits are received and stored as 17 bytes in entries 0 to 16, in the same bit order as R3.
- R5: `rd_data` shows the entry at the read pointer. Each `rd_en` cycle advances the pointer, and it wraps from 16 back to 0. While `ptr_clr` is 1 the pointer is held at 0.
- R6: The CRC7 uses the polynomial x^7+x^3+1 with an initial value of 0. It covers frame bits 47 down to 8 of a short response, and bits 127 down to 8 of a long one. The received CRC sits in bits 7 down to 1, and bit 0 is the end bit. When `crc_off` is 0 at the last bit, `crc_ok` is 1 on a match and 0 on a mismatch.
- R7: When `crc_off` is 1 at the last bit, `crc_ok` is 1 whatever CRC was received.
- R8: At the end of a frame, `fmt_ok` is 1 exactly when the bit after the start bit is 0 and the last bit is 1.
- R9: If 64 sampled bits in a row are all 1 while the block waits for a start bit, the wait ends on the 64th. `resp_done` is set, `fmt_ok` is cleared, `crc_ok` takes the value of `crc_off`, and `busy` falls. After 63 such bits the block is still waiting.
- R10: `resp_done` is set at the end of each frame or wait that ends in a time-out, and holds until `resp_done_clr`. `irq` is 1 exactly when `resp_done` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe that samples the command line |
| cmd_line | input | 1 | Serial command line from the card |
| rx_en | input | 1 | A response is expected for this command |
| long_fmt | input | 1 | 0: 48-bit response, 1: 136-bit response |
| crc_off | input | 1 | Skip the CRC7 comparison |
| cmd_done | input | 1 | End-of-command pulse from the transmitter |
| ptr_clr | input | 1 | Holds the read pointer at 0 while high |
| rd_en | input | 1 | Advance the read pointer by one byte |
| rd_data | output | 8 | Byte at the read pointer |
| busy | output | 1 | Waiting for or receiving a response |
| crc_ok | output | 1 | CRC7 status of the last response |
| fmt_ok | output | 1 | Format status of the last response |
| resp_done | output | 1 | Sticky end-of-response flag |
| resp_done_clr | input | 1 | Clears `resp_done` |
| irq_en | input | 1 | Enables the interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `cmd_done` is pulsed only once per command.
- `crc_off` is steady across the last bit of a frame.
- `bit_en` is a single-cycle strobe.

Read-pointer properties further assume that software clears the pointer by holding `ptr_clr` high, not by racing it against `rd_en`. The stimulus drives every input on the falling clock edge. It raises `cmd_done` for exactly one cycle, holds the format and CRC controls constant across each frame, and never asserts `rd_en` together with `ptr_clr`.

// File: rtl/sd_resp_rx.sv
module sd_resp_rx #(
  parameter int DEPTH      = 17,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int CRC_LO     = 8,
  parameter int CRC_HI     = 127,
  parameter int TIMEOUT    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       cmd_line,
  input  logic       rx_en,
  input  logic       long_fmt,
  input  logic       crc_off,
  input  logic       cmd_done,
  input  logic       ptr_clr,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       crc_ok,
  output logic       fmt_ok,
  output logic       resp_done,
  input  logic       resp_done_clr,
  input  logic       irq_en,
  output logic       irq
);
  localparam int KW = $clog2(LONG_BITS);
  localparam int TW = $clog2(TIMEOUT);
  localparam int PW = $clog2(DEPTH);
  localparam int WW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {IDLE, HUNT, SHIFT} st_t;

  st_t           state;
  logic [KW-1:0] k;
  logic [TW-1:0] tcnt;
  logic [6:0]    sh, crc, rcrc;
  logic          txb, long_q;
  logic [WW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [7:0]    mem [DEPTH];

  logic [KW:0] last_pos, pos;
  logic        take, in_crc, in_rcrc, fb, last;
  logic [6:0]  crc_nx;

  assign last_pos = long_q ? (KW+1)'(LONG_BITS - 1) : (KW+1)'(SHORT_BITS - 1);
  assign pos      = last_pos - {1'b0, k};
  assign take     = bit_en && (state == SHIFT || (state == HUNT && !cmd_line));
  assign in_crc   = (pos >= (KW+1)'(CRC_LO)) && (pos <= (KW+1)'(CRC_HI));
  assign in_rcrc  = (pos >= (KW+1)'(1)) && (pos < (KW+1)'(CRC_LO));
  assign last     = (pos == '0);
  assign fb       = cmd_line ^ crc[6];
  assign crc_nx   = {crc[5:3], crc[2] ^ fb, crc[1:0], fb};

  assign busy    = (state != IDLE);
  assign irq     = resp_done & irq_en;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      k         <= '0;
      tcnt      <= '0;
      sh        <= '0;
      crc       <= '0;
      rcrc      <= '0;
      txb       <= 1'b0;
      long_q    <= 1'b0;
      wptr      <= '0;
      resp_done <= 1'b0;
      crc_ok    <= 1'b0;
      fmt_ok    <= 1'b0;
    end else begin
      if (resp_done_clr) resp_done <= 1'b0;
      case (state)
        IDLE: if (cmd_done && rx_en) begin
          state  <= HUNT;
          tcnt   <= '0;
          k      <= '0;
          crc    <= '0;
          wptr   <= '0;
          long_q <= long_fmt;
        end
        HUNT: if (bit_en && cmd_line) begin
          if (tcnt == TW'(TIMEOUT - 1)) begin
            state     <= IDLE;
            resp_done <= 1'b1;
            fmt_ok    <= 1'b0;
            crc_ok    <= crc_off;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ;
      endcase
      if (take) begin
        sh <= {sh[5:0], cmd_line};
        if (in_crc)  crc  <= crc_nx;
        if (in_rcrc) rcrc <= {rcrc[5:0], cmd_line};
        if (k == KW'(1)) txb <= cmd_line;
        if (k[2:0] == 3'd7) wptr <= wptr + 1'b1;
        if (last) begin
          state     <= IDLE;
          resp_done <= 1'b1;
          crc_ok    <= crc_off || (crc == rcrc);
          fmt_ok    <= !txb && cmd_line;
        end else begin
          state <= SHIFT;
          k     <= k + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && k[2:0] == 3'd7) mem[PW'(wptr)] <= {sh, cmd_line};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr)
      rptr <= '0;
    else if (rd_en)
      rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
  end
endmodule

// File: rtl/sd_resp_rx_chk.sv
module sd_resp_rx_chk #(
  parameter int DEPTH = 17
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_done,
  input logic                     rx_en,
  input logic                     busy,
  input logic                     resp_done,
  input logic                     resp_done_clr,
  input logic                     crc_off,
  input logic                     crc_ok,
  input logic                     fmt_ok,
  input logic                     ptr_clr,
  input logic [$clog2(DEPTH)-1:0] rptr,
  input logic [$clog2(DEPTH+1)-1:0] wptr
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(cmd_done && rx_en) |=> !busy);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done && !resp_done_clr |=> resp_done);

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_done) |-> $past(busy));

  // R7
  crc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_done) && $past(crc_off) |-> crc_ok);

  // R8
  fmt_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_ok) |-> $past(busy));

  // R5
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> rptr == '0);

  // R4
  wptr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind sd_resp_rx sd_resp_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .rx_en(rx_en),
  .busy(busy), .resp_done(resp_done), .resp_done_clr(resp_done_clr),
  .crc_off(crc_off), .crc_ok(crc_ok), .fmt_ok(fmt_ok),
  .ptr_clr(ptr_clr), .rptr(rptr), .wptr(wptr)
);

// File: tb/test_sd_resp_rx.sv
`timescale 1ns/1ps
module test_sd_resp_rx;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, cmd_line = 1, rx_en = 0, long_fmt = 0, crc_off = 0;
  logic cmd_done = 0, ptr_clr = 0, rd_en = 0, resp_done_clr = 0, irq_en = 0;
  logic [7:0] rd_data;
  logic busy, crc_ok, fmt_ok, resp_done, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sd_resp_rx i_sd_resp_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cmd_line(cmd_line),
    .rx_en(rx_en), .long_fmt(long_fmt), .crc_off(crc_off), .cmd_done(cmd_done),
    .ptr_clr(ptr_clr), .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
    .crc_ok(crc_ok), .fmt_ok(fmt_ok), .resp_done(resp_done),
    .resp_done_clr(resp_done_clr), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc_div(input logic [135:0] f, input int hi);
    logic [7:0] rem = '0;
    for (int p = hi; p >= 1; p--) begin
      rem = {rem[6:0], (p >= 8) ? f[p] : 1'b0};
      if (rem[7]) rem = rem ^ 8'h89;
    end
    return rem[6:0];
  endfunction

  function automatic logic [135:0] mk(input bit lng, input logic [119:0] pay,
                                      input bit txb, input bit endb, input bit bad);
    logic [135:0] f = '0;
    if (lng) begin
      f[134] = txb; f[133:128] = 6'h3F; f[127:8] = pay;
      f[7:1] = crc_div(f, 127);
    end else begin
      f[46] = txb; f[45:8] = pay[37:0];
      f[7:1] = crc_div(f, 47);
    end
    if (bad) f[1] = ~f[1];
    f[0] = endb;
    return f;
  endfunction

  task automatic arm();
    @(negedge clk); cmd_done = 1; resp_done_clr = 1;
    @(negedge clk); cmd_done = 0; resp_done_clr = 0;
  endtask

  task automatic send(input logic [135:0] f, input int n, input int lead);
    for (int i = 0; i < lead; i++) begin
      @(negedge clk); bit_en = 1; cmd_line = 1;
    end
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_en = 1; cmd_line = f[i];
    end
    @(negedge clk); bit_en = 0; cmd_line = 1;
  endtask

  task automatic readback(input string req, input logic [135:0] f, input int n);
    @(negedge clk); ptr_clr = 1;
    @(negedge clk); ptr_clr = 0;
    for (int i = 0; i < n / 8; i++) begin
      chk(req, $sformatf("byte %0d", i), rd_data, f[n - 1 - 8*i -: 8]);
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic t_reset();
    chk("R10", "reset resp_done", resp_done, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R10", "reset irq", irq, 0);
  endtask

  task automatic t_no_rx();
    logic [135:0] f = mk(0, 120'h12_3456_789A, 0, 1, 0);
    rx_en = 0; long_fmt = 0;
    arm();
    chk("R1", "busy without rx_en", busy, 0);
    send(f, 48, 0);
    chk("R1", "resp_done without rx_en", resp_done, 0);
    rx_en = 1;
  endtask

  task automatic t_short();
    logic [135:0] f = mk(0, 120'h25_C0FF_EE11, 0, 1, 0);
    long_fmt = 0; crc_off = 0;
    arm();
    chk("R1", "busy after arm", busy, 1);
    send(f, 48, 5);
    chk("R2", "done after leading ones", resp_done, 1);
    chk("R6", "short crc_ok", crc_ok, 1);
    chk("R8", "short fmt_ok", fmt_ok, 1);
    chk("R3", "busy after frame", busy, 0);
    readback("R3", f, 48);
  endtask

  task automatic t_long();
    logic [135:0] f = mk(1, 120'hDEAD_BEEF_0123_4567_89AB_CDEF_5A5A_A5, 0, 1, 0);
    long_fmt = 1; crc_off = 0;
    arm();
    send(f, 136, 0);
    chk("R6", "long crc_ok", crc_ok, 1);
    chk("R8", "long fmt_ok", fmt_ok, 1);
    readback("R4", f, 136);
    chk("R5", "wrap to entry 0", rd_data, f[135:128]);
    for (int i = 0; i < 3; i++) begin
      rd_en = 1; @(negedge clk); rd_en = 0;
    end
    chk("R5", "entry 3", rd_data, f[111:104]);
    ptr_clr = 1; @(negedge clk); ptr_clr = 0;
    chk("R5", "ptr_clr back to 0", rd_data, f[135:128]);
  endtask

  task automatic t_crc();
    logic [135:0] f = mk(0, 120'h3A_5566_7788, 0, 1, 1);
    long_fmt = 0; crc_off = 0;
    arm(); send(f, 48, 2);
    chk("R6", "bad crc flagged", crc_ok, 0);
    chk("R8", "fmt ok with bad crc", fmt_ok, 1);
    crc_off = 1;
    arm(); send(f, 48, 2);
    chk("R7", "crc_off forces ok", crc_ok, 1);
    crc_off = 0;
    f = mk(1, 120'h1, 0, 1, 1);
    long_fmt = 1;
    arm(); send(f, 136, 1);
    chk("R6", "long bad crc flagged", crc_ok, 0);
  endtask

  task automatic t_fmt();
    logic [135:0] f = mk(0, 120'h11_2233_4455, 1, 1, 0);
    long_fmt = 0;
    arm(); send(f, 48, 0);
    chk("R8", "tx bit 1", fmt_ok, 0);
    f = mk(0, 120'h11_2233_4455, 0, 0, 0);
    arm(); send(f, 48, 0);
    chk("R8", "end bit 0", fmt_ok, 0);
  endtask

  task automatic t_timeout();
    logic [135:0] f = mk(0, 120'h0F_0F0F_0F0F, 0, 1, 0);
    arm(); send(f, 48, 0);
    chk("R8", "fmt_ok set before timeout", fmt_ok, 1);
    crc_off = 0;
    arm();
    for (int i = 0; i < 63; i++) begin
      @(negedge clk); bit_en = 1; cmd_line = 1;
    end
    @(negedge clk); bit_en = 0;
    chk("R9", "still waiting after 63", busy, 1);
    chk("R9", "no done after 63", resp_done, 0);
    bit_en = 1; @(negedge clk); bit_en = 0;
    chk("R9", "timeout done", resp_done, 1);
    chk("R9", "timeout fmt_ok", fmt_ok, 0);
    chk("R9", "timeout crc_ok", crc_ok, 0);
    chk("R9", "timeout busy", busy, 0);
  endtask

  task automatic t_irq();
    irq_en = 0; @(negedge clk);
    chk("R10", "irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R10", "irq raised", irq, 1);
    repeat (3) @(negedge clk);
    chk("R10", "done sticky", resp_done, 1);
    resp_done_clr = 1; @(negedge clk); resp_done_clr = 0;
    chk("R10", "done cleared", resp_done, 0);
    chk("R10", "irq cleared", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_rx();
    t_short();
    t_long();
    t_crc();
    t_fmt();
    t_timeout();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule